// File: doc/BRIEF.md
# Video Line Packet Buffer

This block holds received video-line packets in a 2048-byte on-chip RAM. The RAM is cut into 44-byte rows. Row 0 is kept back for control information and is not part of the packet ring. Rows 1 to 45 form a circular ring of packet slots. A capture engine writes each incoming line as one 44-byte packet into the next free slot. Every packet starts with two information bytes, for the line/field and the data type. For teletext these are followed by a 2-byte magazine/row group and 40 payload bytes. The block stores all 44 bytes without reading any of them.

The host sees a single 8-bit data port. Each read strobe returns the byte under an internal read pointer and then moves the pointer on by one, so bytes leave in the order they arrived. Three commands move the pointer: back to the first packet slot, back to the start of the slot being read, or forward to the start of the following slot. The block keeps a count of packets that are committed and not yet released. It also raises a sticky flag when a packet arrives while every slot is occupied.

Top module: `line_packet_buffer`

## Requirements
- R1: After a synchronous active-high reset, `availCount`, `overflow` and `rdData` are 0. The read pointer and the write pointer both sit at byte 0 of slot 1, which covers RAM addresses 44 to 87.
- R2: A packet is 44 accepted bytes, and its first byte is marked with `capSof`. Byte i of the packet is stored at address slot*44+i. Slots are used in the order 1, 2, …, 45, 1, …. `availCount` goes up by one in the cycle after the 44th byte is accepted.
- R3: A `capSof` byte that arrives while `availCount` is 45 drops the whole packet. That byte and every following byte up to the next `capSof` leave the RAM and the count untouched. The drop sets `overflow`, which stays set until it is cleared.
- R4: A `capSof` that arrives before the 44th byte of the current packet abandons that partial packet. The new packet then restarts at byte 0 of the same slot.
- R5: A `hostRd` pulse with no command in the same cycle places the byte at the read pointer on `rdData` one cycle later and moves the pointer to the next byte. `rdData` holds its value until the next accepted read.
- R6: A read of byte 43 moves the pointer to byte 0 of the following slot (45 wraps to 1) and releases the slot. A release lowers `availCount` by one, unless the count is already 0.
- R7: `cmdNext` moves the pointer to byte 0 of the following slot (45 wraps to 1) and releases one packet, with the same saturation as R6.
- R8: `cmdRewind` moves the pointer to byte 0 of the current slot and leaves `availCount` unchanged.
- R9: `cmdRestart` moves the pointer to byte 0 of slot 1 and leaves `availCount` unchanged.
- R10: The commands rank `cmdRestart` over `cmdNext` over `cmdRewind` over `hostRd`. A read strobe in the same cycle as any command is dropped, and `rdData` stays unchanged.
- R11: `ovfClr` clears `overflow` in the next cycle. If a drop (R3) happens in the same cycle, the set wins. A release and a commit in the same cycle leave `availCount` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| capWrEn | input | 1 | Capture byte valid |
| capSof | input | 1 | Marks the first byte of a packet (qualified by capWrEn) |
| capData | input | 8 | Capture byte |
| hostRd | input | 1 | Host read strobe, one byte per cycle |
| cmdRestart | input | 1 | Move read pointer to slot 1, byte 0 |
| cmdNext | input | 1 | Move read pointer to the next slot and release one packet |
| cmdRewind | input | 1 | Move read pointer to byte 0 of the current slot |
| ovfClr | input | 1 | Clear the overflow flag |
| rdData | output | 8 | Last byte read |
| availCount | output | 6 | Committed packets not yet released |
| overflow | output | 1 | Sticky flag: a packet was dropped on a full buffer |

## Verification
The bench pushes the writer all the way around the ring so that slot 45 wraps to slot 1, then fills the buffer to 45 packets. A design with a wrong wrap would overwrite the reserved row or skip a slot, and a wrong full test would accept a 46th packet. The bench also aims at release with the count at 0, at a commit that coincides with a release, and at a read strobe that collides with a command. A design that got any of these wrong would let the count wrap below zero, drift by one, or update `rdData` when it should hold. An aborted partial packet and an overflow set and clear in the same cycle check that the slot is reused and that the set wins.

// File: rtl/pktbuf_pkg.sv
`timescale 1ns/1ps
package pktbuf_pkg;
  localparam int unsigned BUF_BYTES  = 2048;
  localparam int unsigned SLOT_BYTES = 44;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned ROWS       = BUF_BYTES / SLOT_BYTES;
  localparam int unsigned NUM_SLOTS  = ROWS - 1;
  localparam int unsigned ADDR_W     = $clog2(BUF_BYTES);
  localparam int unsigned SLOT_W     = $clog2(ROWS);
  localparam int unsigned BYTE_W     = $clog2(SLOT_BYTES);
  localparam int unsigned CNT_W      = $clog2(NUM_SLOTS + 1);

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic              re;
    logic [ADDR_W-1:0] raddr;
  } pb_strobe_t;

  function automatic logic [ADDR_W-1:0] slotAddr(input logic [SLOT_W-1:0] s,
                                                 input logic [BYTE_W-1:0] b);
    return ADDR_W'(s) * ADDR_W'(SLOT_BYTES) + ADDR_W'(b);
  endfunction

  function automatic logic [SLOT_W-1:0] nextSlot(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(NUM_SLOTS)) ? SLOT_W'(1) : s + SLOT_W'(1);
  endfunction
endpackage

// File: rtl/pktbuf_ram.sv
`timescale 1ns/1ps
module pktbuf_ram
  import pktbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  pb_strobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (strobe.we) mem[strobe.waddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)            rdData <= '0;
    else if (strobe.re) rdData <= mem[strobe.raddr];
  end

  // R10: rdData only moves on an accepted read
  a_r10_hold_without_read: assert property (@(posedge clk) disable iff (rst)
    !strobe.re |=> $stable(rdData));
  // R2: the reserved control row is never written by capture
  a_r2_no_reserved_write: assert property (@(posedge clk) disable iff (rst)
    strobe.we |-> strobe.waddr >= ADDR_W'(SLOT_BYTES));
endmodule

// File: rtl/pktbuf_ctrl.sv
`timescale 1ns/1ps
module pktbuf_ctrl
  import pktbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             capWrEn,
  input  logic             capSof,
  input  logic             hostRd,
  input  logic             cmdRestart,
  input  logic             cmdNext,
  input  logic             cmdRewind,
  input  logic             ovfClr,
  output pb_strobe_t       strobe,
  output logic [CNT_W-1:0] availCount,
  output logic             overflow
);
  localparam logic [BYTE_W-1:0] LAST_BYTE  = BYTE_W'(SLOT_BYTES - 1);
  localparam logic [SLOT_W-1:0] FIRST_SLOT = SLOT_W'(1);

  logic [SLOT_W-1:0] wrSlot, rdSlot;
  logic [BYTE_W-1:0] wrByte, rdByte, wrIdx;
  logic              capActive, isFull, dropNow, wrAccept, wrLast;
  logic              anyCmd, rdAccept, rdLast, slotRelease;

  always_comb begin
    isFull      = (availCount == CNT_W'(NUM_SLOTS));
    dropNow     = capWrEn && capSof && isFull;
    wrAccept    = capWrEn && (capSof ? !isFull : capActive);
    wrIdx       = capSof ? '0 : wrByte;
    wrLast      = wrAccept && (wrIdx == LAST_BYTE);
    anyCmd      = cmdRestart || cmdNext || cmdRewind;
    rdAccept    = hostRd && !anyCmd;
    rdLast      = rdAccept && (rdByte == LAST_BYTE);
    slotRelease = (cmdNext && !cmdRestart) || rdLast;
    strobe.we    = wrAccept;
    strobe.waddr = slotAddr(wrSlot, wrIdx);
    strobe.re    = rdAccept;
    strobe.raddr = slotAddr(rdSlot, rdByte);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrSlot    <= FIRST_SLOT;
      wrByte    <= '0;
      capActive <= 1'b0;
    end else if (dropNow) begin
      capActive <= 1'b0;
    end else if (wrAccept) begin
      if (wrLast) begin
        wrSlot    <= nextSlot(wrSlot);
        wrByte    <= '0;
        capActive <= 1'b0;
      end else begin
        wrByte    <= wrIdx + BYTE_W'(1);
        capActive <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdSlot <= FIRST_SLOT;
      rdByte <= '0;
    end else if (cmdRestart) begin
      rdSlot <= FIRST_SLOT;
      rdByte <= '0;
    end else if (cmdNext) begin
      rdSlot <= nextSlot(rdSlot);
      rdByte <= '0;
    end else if (cmdRewind) begin
      rdByte <= '0;
    end else if (rdAccept) begin
      if (rdLast) begin
        rdSlot <= nextSlot(rdSlot);
        rdByte <= '0;
      end else begin
        rdByte <= rdByte + BYTE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      availCount <= '0;
      overflow   <= 1'b0;
    end else begin
      availCount <= availCount + CNT_W'(wrLast)
                  - CNT_W'(slotRelease && (availCount != '0));
      if (dropNow)     overflow <= 1'b1;
      else if (ovfClr) overflow <= 1'b0;
    end
  end

  // R2: count never exceeds the slot ring
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    availCount <= CNT_W'(NUM_SLOTS));
  // R11: count moves by at most one per cycle
  a_r11_count_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (availCount == $past(availCount) ||
              availCount == $past(availCount) + CNT_W'(1) ||
              availCount + CNT_W'(1) == $past(availCount)));
  // R3: overflow is sticky
  a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow && !ovfClr |=> overflow);
  // R11: clear works when no drop competes
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    ovfClr && !capSof |=> !overflow);
  // R9: restart lands on slot 1 byte 0
  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    cmdRestart |=> (rdSlot == FIRST_SLOT && rdByte == '0));
  // R8: rewind keeps the slot
  a_r8_rewind: assert property (@(posedge clk) disable iff (rst)
    cmdRewind && !cmdRestart && !cmdNext |=> (rdByte == '0 && rdSlot == $past(rdSlot)));
  // R6: pointers stay inside the packet ring
  a_r6_ptr_range: assert property (@(posedge clk) disable iff (rst)
    rdByte <= LAST_BYTE && rdSlot >= FIRST_SLOT && rdSlot <= SLOT_W'(NUM_SLOTS));
endmodule

// File: rtl/line_packet_buffer.sv
`timescale 1ns/1ps
module line_packet_buffer
  import pktbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              capWrEn,
  input  logic              capSof,
  input  logic [DATA_W-1:0] capData,
  input  logic              hostRd,
  input  logic              cmdRestart,
  input  logic              cmdNext,
  input  logic              cmdRewind,
  input  logic              ovfClr,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  availCount,
  output logic              overflow
);
  pb_strobe_t strobe;

  pktbuf_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .capWrEn    (capWrEn),
    .capSof     (capSof),
    .hostRd     (hostRd),
    .cmdRestart (cmdRestart),
    .cmdNext    (cmdNext),
    .cmdRewind  (cmdRewind),
    .ovfClr     (ovfClr),
    .strobe     (strobe),
    .availCount (availCount),
    .overflow   (overflow)
  );

  pktbuf_ram u_ram (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wrData (capData),
    .rdData (rdData)
  );
endmodule

// File: tb/line_packet_buffer_tb.sv
`timescale 1ns/1ps
module line_packet_buffer_tb;
  import pktbuf_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic capWrEn = 0, capSof = 0, hostRd = 0, cmdRestart = 0, cmdNext = 0, cmdRewind = 0, ovfClr = 0;
  logic [7:0] capData = '0;
  logic [7:0] rdData;
  logic [CNT_W-1:0] availCount;
  logic overflow;

  always #2.5 clk = ~clk;

  line_packet_buffer u_dut (
    .clk(clk), .rst(rst), .capWrEn(capWrEn), .capSof(capSof), .capData(capData),
    .hostRd(hostRd), .cmdRestart(cmdRestart), .cmdNext(cmdNext), .cmdRewind(cmdRewind),
    .ovfClr(ovfClr), .rdData(rdData), .availCount(availCount), .overflow(overflow)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string curReq = "R1";

  int mMem [BUF_BYTES];
  int mWrSlot = 1, mWrByte = 0, mRdSlot = 1, mRdByte = 0, mCount = 0, mRd = 0;
  bit mActive = 0, mOvf = 0;

  function automatic int nxt(input int s);
    return (s == NUM_SLOTS) ? 1 : s + 1;
  endfunction

  task automatic compare();
    checks++;
    if (rdData !== 8'(mRd)) begin
      errors++; $display("FAIL %s rdData actual %0h expected %0h", curReq, rdData, mRd);
    end
    checks++;
    if (availCount !== CNT_W'(mCount)) begin
      errors++; $display("FAIL %s availCount actual %0d expected %0d", curReq, availCount, mCount);
    end
    checks++;
    if (overflow !== mOvf) begin
      errors++; $display("FAIL %s overflow actual %0b expected %0b", curReq, overflow, mOvf);
    end
  endtask

  task automatic step(input bit wr, input bit sof, input int d, input bit rd,
                      input bit rs, input bit nx, input bit rw, input bit clr);
    int idx;
    bit rel, com, setO;
    capWrEn = wr; capSof = sof; capData = 8'(d); hostRd = rd;
    cmdRestart = rs; cmdNext = nx; cmdRewind = rw; ovfClr = clr;
    rel = 0; com = 0; setO = 0; idx = -1;
    if (rs) begin mRdSlot = 1; mRdByte = 0; end
    else if (nx) begin mRdSlot = nxt(mRdSlot); mRdByte = 0; rel = 1; end
    else if (rw) mRdByte = 0;
    else if (rd) begin
      mRd = mMem[mRdSlot * SLOT_BYTES + mRdByte];
      if (mRdByte == SLOT_BYTES - 1) begin mRdSlot = nxt(mRdSlot); mRdByte = 0; rel = 1; end
      else mRdByte++;
    end
    if (wr) begin
      if (sof) begin
        if (mCount == NUM_SLOTS) begin setO = 1; mActive = 0; end
        else idx = 0;
      end else if (mActive) idx = mWrByte;
      if (idx >= 0) begin
        mMem[mWrSlot * SLOT_BYTES + idx] = d & 255;
        if (idx == SLOT_BYTES - 1) begin com = 1; mWrSlot = nxt(mWrSlot); mWrByte = 0; mActive = 0; end
        else begin mWrByte = idx + 1; mActive = 1; end
      end
    end
    mCount = mCount + int'(com) - ((rel && mCount > 0) ? 1 : 0);
    if (setO) mOvf = 1; else if (clr) mOvf = 0;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic putPkt(input int p, input int len);
    for (int i = 0; i < len; i++) step(1, i == 0, p * 7 + i * 3, 0, 0, 0, 0, 0);
  endtask

  task automatic readN(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired during %s", curReq);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    curReq = "R1"; compare();
    curReq = "R2"; putPkt(0, 44); putPkt(1, 44); putPkt(2, 44);
    curReq = "R5"; readN(5);
    curReq = "R8"; step(0, 0, 0, 0, 0, 0, 1, 0); readN(3);
    curReq = "R7"; step(0, 0, 0, 0, 0, 1, 0, 0);
    curReq = "R6"; readN(44);
    curReq = "R10"; step(0, 0, 0, 1, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0, 1, 0);
    curReq = "R7"; step(0, 0, 0, 0, 0, 1, 0, 0);
    curReq = "R9"; step(0, 0, 0, 0, 1, 1, 0, 0); readN(2);
    curReq = "R4"; putPkt(3, 10); putPkt(4, 44);
    curReq = "R2"; for (int p = 5; p < 49; p++) putPkt(p, 44);
    curReq = "R3"; putPkt(49, 44); readN(1);
    curReq = "R11"; step(1, 1, 9, 0, 0, 0, 0, 1); step(0, 0, 0, 0, 0, 0, 0, 1);
    curReq = "R9"; step(0, 0, 0, 0, 1, 0, 0, 0);
    curReq = "R6"; readN(44);
    curReq = "R11"; putPkt(50, 43); step(1, 0, 50 * 7 + 43 * 3, 0, 0, 1, 0, 0);
    curReq = "R7"; for (int i = 0; i < 50; i++) step(0, 0, 0, 0, 0, 1, 0, 0);
    curReq = "R2"; putPkt(51, 44); step(0, 0, 0, 0, 1, 0, 0, 0); readN(44);
    finishRun();
  end
endmodule